// File: doc/BRIEF.md
# Time-Multiplexed-Output Neural Layer Engine

This block evaluates one fully connected neural layer with signed fixed-point arithmetic. Input samples stream into a tapped delay line, one sample per accepted cycle. When the line is full, a start pulse runs a pass. In each cycle of the pass, every input position reads one weight word from its own local memory. All multipliers then work in parallel, and one complete inner product leaves the block. A pass therefore emits one output per clock, in ascending node order, each tagged with its node index.

Each input position has its own weight memory with one word per output node. The memory is a recirculating store: every word read for computation is written straight back, so the stored weights survive any number of passes and no refresh cycles are needed. Between passes, a write port addressed by node (row) and input position (column) programs single words.

A mode bit selects between full-width operation and segmented operation. In full-width mode the whole line forms one sum. In segmented mode the line splits into three equal sections, and each section yields its own inner product on the same cycle. This suits moving-window workloads where three short vectors share one engine.

Top module: `tmo_layer_engine`

## Requirements
- R1: After reset, `outValid`, `done` and `wrReject` are 0, and every stored weight is 0, so a pass before any write yields all-zero lanes.
- R2: Each cycle in which `sampleValid` is high and no pass is running shifts `sampleData` into line position 0, and every older sample moves up one position. Column c of the weight store multiplies the sample in position c, which is the sample received c accepted samples before the most recent one.
- R3: A `start` sampled while idle makes `outValid` high for exactly NUM_OUT consecutive cycles. The first of these is the second cycle after the one in which `start` was sampled. `outNode` counts 0, 1, … NUM_OUT-1 across them.
- R4: In full-width mode (`segMode`=0 when `start` is sampled), lane 0 (`outSum[ACC_W-1:0]`) carries the signed sum over all positions c of sample(c) × weight(node, c), with four-quadrant signed products. Lanes 1 and 2 are 0.
- R5: In segmented mode (`segMode`=1 when `start` is sampled), lane s (`outSum[s*ACC_W +: ACC_W]`) carries the signed sum over positions s*SEG_LEN to s*SEG_LEN+SEG_LEN-1 only.
- R6: `done` is high in the same cycle as the output for node NUM_OUT-1 and in no other cycle.
- R7: A pass leaves every stored weight unchanged, so a repeated pass over the same line gives identical results.
- R8: A `wrReq` sampled during a pass changes no weight. It is flagged by `wrReject` being high in the following cycle. A write sampled while idle never raises `wrReject`.
- R9: `sampleValid` during a pass does not change the line. The next pass shows the line as it was before that pass.
- R10: A `start` sampled during a pass neither restarts nor extends it. `outValid` falls after node NUM_OUT-1.
- R11: Full-scale operands (samples of -128, weights of -32 or +31 at every position) produce exact sums with no overflow.
- R12: A write and a `start` sampled in the same idle cycle both take effect, and the new word is already used by that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Shift `sampleData` into the line |
| sampleData | input | 8 | Signed input sample |
| wrReq | input | 1 | Weight write request |
| wrRow | input | 5 | Output node (row) of the word to write |
| wrCol | input | 6 | Input position (column) of the word to write |
| wrData | input | 6 | Signed weight value |
| segMode | input | 1 | 0 = one full-width sum, 1 = three section sums; sampled with `start` |
| start | input | 1 | Begin a pass over all output nodes |
| outValid | output | 1 | Output lanes hold a result |
| outNode | output | 5 | Node index of the current result |
| outSum | output | 60 | Three signed lanes of ACC_W = 20 bits, lane s at bits s*20 upward |
| done | output | 1 | Final node of the pass is on the output |
| wrReject | output | 1 | A write was refused one cycle earlier because a pass was running |

## Verification
Two events can share one cycle: a weight write and the start of a pass. Both are idle-time actions, and they interact through the same stored word. The bench drives `wrReq` and `start` on one edge with a new value for a word that node 0 reads immediately, then checks that node 0 already reflects the new weight. The opposite case is a write landing while the memories are rotating. It is provoked inside a running pass and judged two ways: `wrReject` must pulse, and the following pass must reproduce the old results exactly.

// File: rtl/nle_pkg.sv
package nle_pkg;
  typedef struct packed {
    logic shiftEn;
    logic writeEn;
    logic computeEn;
    logic segSel;
    logic lastRow;
  } nleStrobes_t;
endpackage

// File: rtl/nle_weight_bank.sv
module nle_weight_bank #(
  parameter int DEPTH    = 32,
  parameter int WEIGHT_W = 6,
  parameter int ROW_W    = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       writeEn,
  input  logic [ROW_W-1:0]           wrRow,
  input  logic signed [WEIGHT_W-1:0] wrData,
  input  logic                       rotateEn,
  output logic signed [WEIGHT_W-1:0] headWord
);
  logic signed [WEIGHT_W-1:0] words [DEPTH];

  // Rotation writes each word back as it is consumed; DEPTH steps restore the origin.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) words[k] <= '0;
    end else if (rotateEn) begin
      for (int k = 0; k < DEPTH - 1; k++) words[k] <= words[k+1];
      words[DEPTH-1] <= words[0];
    end else if (writeEn) begin
      words[wrRow] <= wrData;
    end
  end

  assign headWord = words[0];
endmodule

// File: rtl/nle_control.sv
module nle_control
  import nle_pkg::*;
#(
  parameter int NUM_OUT = 32,
  parameter int ROW_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             wrReq,
  input  logic             segMode,
  input  logic             start,
  output nleStrobes_t      strobes,
  output logic [ROW_W-1:0] rowIdx,
  output logic             wrReject
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_OUT - 1);

  logic busy;
  logic segLatched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      rowIdx     <= '0;
      segLatched <= 1'b0;
      wrReject   <= 1'b0;
    end else begin
      wrReject <= wrReq && busy;
      if (busy) begin
        rowIdx <= rowIdx + 1'b1;
        if (rowIdx == LAST_ROW) begin
          busy   <= 1'b0;
          rowIdx <= '0;
        end
      end else if (start) begin
        busy       <= 1'b1;
        rowIdx     <= '0;
        segLatched <= segMode;
      end
    end
  end

  always_comb begin
    strobes.shiftEn   = sampleValid && !busy;
    strobes.writeEn   = wrReq && !busy;
    strobes.computeEn = busy;
    strobes.segSel    = segLatched;
    strobes.lastRow   = (rowIdx == LAST_ROW);
  end
endmodule

// File: rtl/nle_datapath.sv
module nle_datapath
  import nle_pkg::*;
#(
  parameter int NUM_SEG  = 3,
  parameter int SEG_LEN  = 16,
  parameter int NUM_OUT  = 32,
  parameter int SAMPLE_W = 8,
  parameter int WEIGHT_W = 6,
  parameter int ROW_W    = 5,
  parameter int COL_W    = 6,
  parameter int ACC_W    = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  nleStrobes_t                strobes,
  input  logic [ROW_W-1:0]           rowIdx,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic [ROW_W-1:0]           wrRow,
  input  logic [COL_W-1:0]           wrCol,
  input  logic signed [WEIGHT_W-1:0] wrData,
  output logic                       outValid,
  output logic [ROW_W-1:0]           outNode,
  output logic [NUM_SEG*ACC_W-1:0]   outSum,
  output logic                       done
);
  localparam int NUM_IN = NUM_SEG * SEG_LEN;

  logic signed [SAMPLE_W-1:0] taps  [NUM_IN];
  logic signed [WEIGHT_W-1:0] heads [NUM_IN];
  logic signed [ACC_W-1:0]    segSum [NUM_SEG];
  logic signed [ACC_W-1:0]    total;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IN; i++) taps[i] <= '0;
    end else if (strobes.shiftEn) begin
      taps[0] <= sampleData;
      for (int i = 1; i < NUM_IN; i++) taps[i] <= taps[i-1];
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : gBank
    nle_weight_bank #(
      .DEPTH(NUM_OUT), .WEIGHT_W(WEIGHT_W), .ROW_W(ROW_W)
    ) bank (
      .clk     (clk),
      .rstN    (rstN),
      .writeEn (strobes.writeEn && (wrCol == COL_W'(g))),
      .wrRow   (wrRow),
      .wrData  (wrData),
      .rotateEn(strobes.computeEn),
      .headWord(heads[g])
    );
  end

  always_comb begin
    for (int s = 0; s < NUM_SEG; s++) begin
      segSum[s] = '0;
      for (int j = 0; j < SEG_LEN; j++) begin
        segSum[s] = segSum[s] + ACC_W'(taps[s*SEG_LEN+j]) * ACC_W'(heads[s*SEG_LEN+j]);
      end
    end
  end

  always_comb begin
    total = '0;
    for (int s = 0; s < NUM_SEG; s++) total = total + segSum[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outNode  <= '0;
      outSum   <= '0;
      done     <= 1'b0;
    end else begin
      outValid <= strobes.computeEn;
      done     <= strobes.computeEn && strobes.lastRow;
      if (strobes.computeEn) begin
        outNode <= rowIdx;
        for (int s = 0; s < NUM_SEG; s++) begin
          if (strobes.segSel)  outSum[s*ACC_W +: ACC_W] <= segSum[s];
          else if (s == 0)     outSum[s*ACC_W +: ACC_W] <= total;
          else                 outSum[s*ACC_W +: ACC_W] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tmo_layer_engine.sv
module tmo_layer_engine
  import nle_pkg::*;
#(
  parameter int NUM_SEG  = 3,
  parameter int SEG_LEN  = 16,
  parameter int NUM_OUT  = 32,
  parameter int SAMPLE_W = 8,
  parameter int WEIGHT_W = 6,
  localparam int NUM_IN  = NUM_SEG * SEG_LEN,
  localparam int ROW_W   = $clog2(NUM_OUT),
  localparam int COL_W   = $clog2(NUM_IN),
  localparam int ACC_W   = SAMPLE_W + WEIGHT_W + $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [SAMPLE_W-1:0]      sampleData,
  input  logic                     wrReq,
  input  logic [ROW_W-1:0]         wrRow,
  input  logic [COL_W-1:0]         wrCol,
  input  logic [WEIGHT_W-1:0]      wrData,
  input  logic                     segMode,
  input  logic                     start,
  output logic                     outValid,
  output logic [ROW_W-1:0]         outNode,
  output logic [NUM_SEG*ACC_W-1:0] outSum,
  output logic                     done,
  output logic                     wrReject
);
  nleStrobes_t      strobes;
  logic [ROW_W-1:0] rowIdx;

  nle_control #(.NUM_OUT(NUM_OUT), .ROW_W(ROW_W)) ctrl (
    .clk, .rstN, .sampleValid, .wrReq, .segMode, .start,
    .strobes(strobes), .rowIdx(rowIdx), .wrReject(wrReject)
  );

  nle_datapath #(
    .NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .NUM_OUT(NUM_OUT),
    .SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .ACC_W(ACC_W)
  ) dp (
    .clk, .rstN, .strobes(strobes), .rowIdx(rowIdx),
    .sampleData($signed(sampleData)), .wrRow, .wrCol, .wrData($signed(wrData)),
    .outValid, .outNode, .outSum, .done
  );
endmodule

// File: rtl/tmo_layer_engine_chk.sv
module tmo_layer_engine_chk #(
  parameter int NUM_OUT = 32,
  parameter int ROW_W   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic [ROW_W-1:0] outNode,
  input logic             done,
  input logic             wrReq,
  input logic             wrReject
);
  logic [ROW_W:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          runCnt <= '0;
    else if (!outValid) runCnt <= '0;
    else if (done)      runCnt <= '0;
    else                runCnt <= runCnt + 1'b1;
  end

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid); // R6
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == (ROW_W+1)'(NUM_OUT - 1))); // R6
  AST_FIRST_NODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outNode == '0)); // R3
  AST_NODE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !done) |=> (outValid && outNode == $past(outNode) + 1'b1)); // R3
  AST_PASS_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !outValid); // R10
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> $past(wrReq)); // R8
endmodule

bind tmo_layer_engine tmo_layer_engine_chk #(.NUM_OUT(NUM_OUT), .ROW_W(ROW_W)) chkInst (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outNode(outNode),
  .done(done), .wrReq(wrReq), .wrReject(wrReject)
);

// File: tb/tmo_layer_engine_test.sv
module tmo_layer_engine_test;
  localparam int NUM_SEG = 3;
  localparam int SEG_LEN = 16;
  localparam int NUM_OUT = 32;
  localparam int NUM_IN  = NUM_SEG * SEG_LEN;
  localparam int ACC_W   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [7:0] sampleData = '0;
  logic wrReq = 1'b0;
  logic [4:0] wrRow = '0;
  logic [5:0] wrCol = '0;
  logic [5:0] wrData = '0;
  logic segMode = 1'b0;
  logic start = 1'b0;
  logic outValid, done, wrReject;
  logic [4:0] outNode;
  logic [NUM_SEG*ACC_W-1:0] outSum;

  int checks = 0;
  int fails = 0;
  int modelW [NUM_OUT][NUM_IN];
  int modelTap [NUM_IN];

  always #5 clk = ~clk;

  tmo_layer_engine #(.NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .NUM_OUT(NUM_OUT)) uut (
    .clk, .rstN, .sampleValid, .sampleData, .wrReq, .wrRow, .wrCol, .wrData,
    .segMode, .start, .outValid, .outNode, .outSum, .done, .wrReject
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane(input int s);
    return longint'($signed(outSum[s*ACC_W +: ACC_W]));
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < NUM_OUT; r++)
      for (int c = 0; c < NUM_IN; c++) modelW[r][c] = 0;
    for (int c = 0; c < NUM_IN; c++) modelTap[c] = 0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(wrReject == 1'b0, "R1 wrReject", wrReject, 0);
  endtask

  task automatic pushSample(input int v);
    sampleValid = 1'b1;
    sampleData = 8'(v);
    @(negedge clk);
    sampleValid = 1'b0;
    for (int i = NUM_IN - 1; i > 0; i--) modelTap[i] = modelTap[i-1];
    modelTap[0] = v;
  endtask

  task automatic writeW(input int r, input int c, input int v);
    wrReq = 1'b1; wrRow = 5'(r); wrCol = 6'(c); wrData = 6'(v);
    @(negedge clk);
    wrReq = 1'b0;
    modelW[r][c] = v;
    check(wrReject == 1'b0, "R8 idle write not rejected", wrReject, 0);
  endtask

  // disturb: 0 none, 1 write during pass, 2 sample during pass, 3 start during pass
  task automatic runPass(input bit seg, input int disturb, input bit coWrite,
                         input int cwRow, input int cwCol, input int cwVal, input string req);
    longint expLane [NUM_SEG];
    longint tot;
    segMode = seg;
    start = 1'b1;
    if (coWrite) begin
      wrReq = 1'b1; wrRow = 5'(cwRow); wrCol = 6'(cwCol); wrData = 6'(cwVal);
      modelW[cwRow][cwCol] = cwVal;
    end
    @(negedge clk);
    start = 1'b0; wrReq = 1'b0; segMode = 1'b0;
    check(outValid == 1'b0, {req, " R3 latency"}, outValid, 0);
    if (coWrite) check(wrReject == 1'b0, "R12 co-write accepted", wrReject, 0);
    @(negedge clk);
    for (int k = 0; k < NUM_OUT; k++) begin
      for (int s = 0; s < NUM_SEG; s++) begin
        expLane[s] = 0;
        for (int j = 0; j < SEG_LEN; j++)
          expLane[s] += longint'(modelTap[s*SEG_LEN+j]) * longint'(modelW[k][s*SEG_LEN+j]);
      end
      if (!seg) begin
        tot = expLane[0] + expLane[1] + expLane[2];
        expLane[0] = tot; expLane[1] = 0; expLane[2] = 0;
      end
      check(outValid == 1'b1, {req, " R3 valid"}, outValid, 1);
      check(outNode == 5'(k), {req, " R3 node"}, outNode, k);
      check(done == (k == NUM_OUT - 1), {req, " R6 done"}, done, (k == NUM_OUT - 1));
      for (int s = 0; s < NUM_SEG; s++)
        check(lane(s) == expLane[s], {req, seg ? " R5 lane" : " R4 lane"}, lane(s), expLane[s]);
      if (k == 3) begin
        if (disturb == 1) begin
          wrReq = 1'b1; wrRow = 5'd1; wrCol = 6'd2; wrData = 6'(modelW[1][2] + 5);
        end
        if (disturb == 2) begin
          sampleValid = 1'b1; sampleData = 8'd99;
        end
        if (disturb == 3) start = 1'b1;
      end
      if (k == 4) begin
        if (disturb == 1) check(wrReject == 1'b1, "R8 reject flagged", wrReject, 1);
        wrReq = 1'b0; sampleValid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, {req, " R10 pass ended"}, outValid, 0);
    check(done == 1'b0, {req, " R6 done low"}, done, 0);
  endtask

  task automatic testResetZero();
    for (int i = 0; i < NUM_IN; i++) pushSample(i - 20);
    runPass(1'b0, 0, 1'b0, 0, 0, 0, "R1 zero weights");
  endtask

  task automatic testFull();
    for (int r = 0; r < NUM_OUT; r++)
      for (int c = 0; c < NUM_IN; c++) writeW(r, c, ((r * 7 + c * 3) % 64) - 32);
    for (int i = 0; i < NUM_IN; i++) pushSample(((i * 37 + 11) % 256) - 128);
    runPass(1'b0, 0, 1'b0, 0, 0, 0, "R2 R4 full");
  endtask

  task automatic testSeg();
    runPass(1'b1, 0, 1'b0, 0, 0, 0, "R5 segmented");
    runPass(1'b0, 0, 1'b0, 0, 0, 0, "R7 repeat");
  endtask

  task automatic testDisturb();
    runPass(1'b0, 1, 1'b0, 0, 0, 0, "R8 write in pass");
    runPass(1'b0, 2, 1'b0, 0, 0, 0, "R8 R9 after write");
    runPass(1'b1, 3, 1'b0, 0, 0, 0, "R9 R10 start in pass");
  endtask

  task automatic testCoWrite();
    runPass(1'b0, 0, 1'b1, 0, 0, -29, "R12 write with start");
  endtask

  task automatic testExtremes();
    for (int r = 0; r < NUM_OUT; r++)
      for (int c = 0; c < NUM_IN; c++) writeW(r, c, (r % 2 == 0) ? -32 : 31);
    for (int i = 0; i < NUM_IN; i++) pushSample(-128);
    runPass(1'b0, 0, 1'b0, 0, 0, 0, "R11 full scale");
    runPass(1'b1, 0, 1'b0, 0, 0, 0, "R11 full scale seg");
  endtask

  initial begin
    doReset();
    testResetZero();
    testFull();
    testSeg();
    testDisturb();
    testCoWrite();
    testExtremes();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(10 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule